// File: doc/BRIEF.md
# Reset and Clock Start-Up Sequencer

This block brings a device out of reset. It runs in an always-on reference clock domain and accepts three reset requests: power-on, brown-out and external. It holds the internal reset for as long as any request is present. After the last request drops, it runs a power-on delay and then an optional power-up delay. Next to these it runs an oscillator start-up counter that only counts while the crystal oscillator reports that it is running. When the delays end, the block checks whether the configured system clock can be used. A crystal source is usable once it is running and its start-up count is complete. A PLL source is usable once the PLL reports lock. If the clock is usable, the block opens the clock gate and releases reset.

When the clock is not usable at that point, the result depends on the fail-safe monitor. With the monitor enabled, the block switches to the internal fast RC source, raises a clock-failure trap and releases reset at once. With the monitor disabled, the block keeps the device in reset until the clock becomes usable, and this wait can last forever. The configuration is captured only while a reset request is held: the clock source, the monitor and power-up enables, and the brown-out level select for the analog detector.

Top module: `rst_clk_sequencer`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1 and `clk_gate_en`, `clk_trap` and `fell_back` are 0. Any of `por_req`, `bor_req` or `ext_req` drives `sys_rst` to 1 within three reference clock edges.
- R2: When the power-up delay is enabled and the clock is usable, `sys_rst` falls POR_CYCLES + PWRT_CYCLES + 4 edges after the edge at which the last request was first seen low.
- R3: When the power-up delay is disabled and the clock is usable, `sys_rst` falls POR_CYCLES + 3 edges after that same edge.
- R4: The source codes on `cfg_src` are: 0 fast RC, 1 slow RC, 2 external RC, 3 external clock, 4 low-speed crystal, 5 crystal with PLL, 6 external clock with PLL, 7 high-speed crystal. Codes 4, 5 and 7 need `osc_ready` plus OSC_CYCLES counted cycles of `osc_ready`. Codes 5 and 6 need `pll_lock`. Codes 0 to 3 are usable at once. After a normal release, `clk_sel` equals the configured code.
- R5: If the clock is not usable when the delays end and the fail-safe monitor is enabled, reset is released at the R2/R3 time. At that release, `clk_trap` and `fell_back` become 1 and `clk_sel` becomes 0.
- R6: If the clock is not usable when the delays end and the monitor is disabled, `sys_rst` stays 1 until the clock becomes usable, and stays 1 indefinitely if it never does.
- R7: `clk_trap` stays 1 until a cycle with `trap_clr` high clears it. `fell_back` keeps its value until the next reset request. A new reset request clears both.
- R8: A reset request that arrives during the sequence aborts it. Timing restarts from the power-on delay, measured from the new release.
- R9: The configuration inputs are captured only while a request is held. Changing them after release has no effect on `clk_sel` or `bor_sel`.
- R10: `bor_sel` carries the captured brown-out level code: 0, 1 or 2 pass unchanged, and code 3 is mapped to 2.
- R11: `clk_gate_en` is always the inverse of `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| por_req | input | 1 | Power-on reset request (level) |
| bor_req | input | 1 | Brown-out reset request (level) |
| ext_req | input | 1 | External reset request (level) |
| cfg_src | input | 3 | Configured system clock source code |
| cfg_fsafe_en | input | 1 | Fail-safe clock monitor enable |
| cfg_pwup_en | input | 1 | Power-up delay enable |
| cfg_bor_lvl | input | 2 | Brown-out trip level code |
| osc_ready | input | 1 | Primary oscillator running indication |
| pll_lock | input | 1 | PLL lock indication |
| trap_clr | input | 1 | Clears the clock-failure trap |
| sys_rst | output | 1 | Internal reset, active high |
| clk_gate_en | output | 1 | System clock gate enable |
| clk_sel | output | 3 | Active clock source code |
| clk_trap | output | 1 | Clock-failure trap level |
| fell_back | output | 1 | Set when the clock fell back to the fast RC source |
| bor_sel | output | 2 | Brown-out level select for the analog detector |

## Verification
The bench builds the block with POR_CYCLES = 8, PWRT_CYCLES = 24 and OSC_CYCLES = 16. With these values, a crystal that runs from the start finishes its start-up count before the power-up delay ends, but not before the power-on delay alone ends. Changing only the power-up enable therefore moves a crystal case between a normal release and a fallback or wait. The short delays also let a late PLL lock or a late oscillator land on either side of the decision point within a window of about a hundred cycles. Cases that would land within a few cycles of that point are avoided.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [2:0] {
    SRC_FAST_RC  = 3'd0,
    SRC_SLOW_RC  = 3'd1,
    SRC_EXT_RC   = 3'd2,
    SRC_EXT_CLK  = 3'd3,
    SRC_XTAL_LO  = 3'd4,
    SRC_XTAL_PLL = 3'd5,
    SRC_EXT_PLL  = 3'd6,
    SRC_XTAL_HI  = 3'd7
  } clk_src_e;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_PON  = 3'd1,
    ST_PWUP = 3'd2,
    ST_WAIT = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_e;

  // Sources that rely on a crystal and its start-up count
  function automatic logic src_is_xtal(input logic [2:0] src);
    return (src == SRC_XTAL_LO) || (src == SRC_XTAL_PLL) || (src == SRC_XTAL_HI);
  endfunction

  // Sources that run through the PLL
  function automatic logic src_uses_pll(input logic [2:0] src);
    return (src == SRC_XTAL_PLL) || (src == SRC_EXT_PLL);
  endfunction

  // Three legal trip settings; the spare code selects the highest one
  function automatic logic [1:0] bor_level_map(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int          WIDTH   = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {WIDTH{RST_VAL}};
      stage2_q <= {WIDTH{RST_VAL}};
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign q_out = stage2_q;

endmodule

// File: rtl/rcs_timer.sv
module rcs_timer #(
  parameter int W     = 8,
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign expired = (cnt_q == W'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && !expired) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rcs_fsm.sv
module rcs_fsm
  import rcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  input  logic       osc_s,
  input  logic       lock_s,
  input  logic [2:0] cfg_src,
  input  logic       cfg_fsafe_en,
  input  logic       cfg_pwup_en,
  input  logic [1:0] cfg_bor_lvl,
  input  logic       trap_clr,
  input  logic       pon_exp,
  input  logic       pwup_exp,
  input  logic       ost_exp,
  output logic       in_hold,
  output logic       in_pon,
  output logic       in_pwup,
  output logic       xtal_sel,
  output logic       sys_rst,
  output logic       clk_gate_en,
  output logic [2:0] clk_sel,
  output logic       clk_trap,
  output logic       fell_back,
  output logic [1:0] bor_sel
);

  seq_state_e state_q, state_d;
  logic [2:0] src_q;
  logic       fsafe_q;
  logic       pwup_q;
  logic [1:0] bor_q;
  logic       fb_q;
  logic       trap_q;
  logic       rst_out_q;
  logic       gate_q;
  logic       fb_set;
  logic       clk_ok;
  logic       decide;

  assign in_hold  = (state_q == ST_HOLD);
  assign in_pon   = (state_q == ST_PON);
  assign in_pwup  = (state_q == ST_PWUP);
  assign xtal_sel = src_is_xtal(src_q);

  // Selected clock usable: crystal running and counted, PLL locked
  assign clk_ok = (!src_is_xtal(src_q) || (osc_s && ost_exp)) &&
                  (!src_uses_pll(src_q) || lock_s);

  assign decide = (in_pon && pon_exp && !pwup_q) || (in_pwup && pwup_exp);

  always_comb begin
    state_d = state_q;
    fb_set  = 1'b0;
    unique case (state_q)
      ST_HOLD: if (!req_s) state_d = ST_PON;
      ST_PON:  if (pon_exp && pwup_q) state_d = ST_PWUP;
      ST_WAIT: if (clk_ok) state_d = ST_RUN;
      default: ;
    endcase
    if (decide) begin
      if (clk_ok) begin
        state_d = ST_RUN;
      end else if (fsafe_q) begin
        state_d = ST_RUN;
        fb_set  = 1'b1;
      end else begin
        state_d = ST_WAIT;
      end
    end
    if (req_s) begin
      state_d = ST_HOLD;
      fb_set  = 1'b0;
    end
  end

  // State and registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HOLD;
      rst_out_q <= 1'b1;
      gate_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      rst_out_q <= (state_d != ST_RUN);
      gate_q    <= (state_d == ST_RUN);
    end
  end

  // Configuration capture, enabled only while a request holds the block
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_FAST_RC;
      fsafe_q <= 1'b0;
      pwup_q  <= 1'b1;
      bor_q   <= 2'd0;
    end else if (in_hold) begin
      src_q   <= cfg_src;
      fsafe_q <= cfg_fsafe_en;
      pwup_q  <= cfg_pwup_en;
      bor_q   <= bor_level_map(cfg_bor_lvl);
    end
  end

  // Fallback status and trap level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q   <= 1'b0;
      trap_q <= 1'b0;
    end else if (in_hold) begin
      fb_q   <= 1'b0;
      trap_q <= 1'b0;
    end else if (fb_set) begin
      fb_q   <= 1'b1;
      trap_q <= 1'b1;
    end else if (trap_clr) begin
      trap_q <= 1'b0;
    end
  end

  assign sys_rst     = rst_out_q;
  assign clk_gate_en = gate_q;
  assign clk_sel     = fb_q ? 3'(SRC_FAST_RC) : src_q;
  assign clk_trap    = trap_q;
  assign fell_back   = fb_q;
  assign bor_sel     = bor_q;

endmodule

// File: rtl/rst_clk_sequencer.sv
module rst_clk_sequencer #(
  parameter int POR_CYCLES  = 64,
  parameter int PWRT_CYCLES = 2048,
  parameter int OSC_CYCLES  = 1024
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       por_req,
  input  logic       bor_req,
  input  logic       ext_req,
  input  logic [2:0] cfg_src,
  input  logic       cfg_fsafe_en,
  input  logic       cfg_pwup_en,
  input  logic [1:0] cfg_bor_lvl,
  input  logic       osc_ready,
  input  logic       pll_lock,
  input  logic       trap_clr,
  output logic       sys_rst,
  output logic       clk_gate_en,
  output logic [2:0] clk_sel,
  output logic       clk_trap,
  output logic       fell_back,
  output logic [1:0] bor_sel
);

  localparam int MAX_A  = (POR_CYCLES > PWRT_CYCLES) ? POR_CYCLES : PWRT_CYCLES;
  localparam int MAX_C  = (MAX_A > OSC_CYCLES) ? MAX_A : OSC_CYCLES;
  localparam int CW     = $clog2(MAX_C + 1);
  localparam int N_TMR  = 3;

  logic       req_any;
  logic       req_s;
  logic [1:0] stat_s;
  logic       in_hold, in_pon, in_pwup, xtal_sel;
  logic [N_TMR-1:0] tmr_en;
  logic [N_TMR-1:0] tmr_exp;

  assign req_any = por_req | bor_req | ext_req;

  rcs_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_req_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d_in  (req_any),
    .q_out (req_s)
  );

  rcs_sync #(.WIDTH(2), .RST_VAL(1'b0)) u_stat_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d_in  ({pll_lock, osc_ready}),
    .q_out (stat_s)
  );

  // Timer 0: power-on delay, 1: power-up delay, 2: oscillator start-up
  assign tmr_en[0] = in_pon;
  assign tmr_en[1] = in_pwup;
  assign tmr_en[2] = stat_s[0] & xtal_sel;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam int LIM = (g == 0) ? POR_CYCLES : (g == 1) ? PWRT_CYCLES : OSC_CYCLES;
    rcs_timer #(.W(CW), .LIMIT(LIM)) u_timer (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .clr     (in_hold),
      .en      (tmr_en[g]),
      .expired (tmr_exp[g])
    );
  end

  rcs_fsm u_fsm (
    .clk          (clk_ref),
    .rst_n        (rst_n),
    .req_s        (req_s),
    .osc_s        (stat_s[0]),
    .lock_s       (stat_s[1]),
    .cfg_src      (cfg_src),
    .cfg_fsafe_en (cfg_fsafe_en),
    .cfg_pwup_en  (cfg_pwup_en),
    .cfg_bor_lvl  (cfg_bor_lvl),
    .trap_clr     (trap_clr),
    .pon_exp      (tmr_exp[0]),
    .pwup_exp     (tmr_exp[1]),
    .ost_exp      (tmr_exp[2]),
    .in_hold      (in_hold),
    .in_pon       (in_pon),
    .in_pwup      (in_pwup),
    .xtal_sel     (xtal_sel),
    .sys_rst      (sys_rst),
    .clk_gate_en  (clk_gate_en),
    .clk_sel      (clk_sel),
    .clk_trap     (clk_trap),
    .fell_back    (fell_back),
    .bor_sel      (bor_sel)
  );

endmodule

// File: rtl/rst_clk_sequencer_chk.sv
module rst_clk_sequencer_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       por_req,
  input logic       bor_req,
  input logic       ext_req,
  input logic       trap_clr,
  input logic       sys_rst,
  input logic       clk_gate_en,
  input logic [2:0] clk_sel,
  input logic       clk_trap,
  input logic       fell_back,
  input logic [1:0] bor_sel
);

  // R11: gate open exactly when reset is released
  p_gate_inverse_r11: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clk_gate_en == !sys_rst);

  // R1: a request reaches the internal reset within three edges
  p_req_resets_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (por_req || bor_req || ext_req) |-> ##3 sys_rst);

  // R5: a trap only rises together with a fallback to the fast RC source
  p_trap_fallback_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_trap) |-> (fell_back && clk_sel == 3'd0 && !sys_rst));

  // R7: trap held while running until cleared
  p_trap_hold_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (clk_trap && !trap_clr && !sys_rst) |=> clk_trap);

  // R7: fallback status keeps its value while running
  p_fb_stable_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !sys_rst |=> $stable(fell_back));

  // R9: selection outputs do not follow configuration after release
  p_cfg_frozen_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !sys_rst |=> ($stable(clk_sel) && $stable(bor_sel)));

  // R10: spare level code never reaches the detector
  p_bor_legal_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    bor_sel != 2'd3);

endmodule

bind rst_clk_sequencer rst_clk_sequencer_chk u_chk (
  .clk_ref     (clk_ref),
  .rst_n       (rst_n),
  .por_req     (por_req),
  .bor_req     (bor_req),
  .ext_req     (ext_req),
  .trap_clr    (trap_clr),
  .sys_rst     (sys_rst),
  .clk_gate_en (clk_gate_en),
  .clk_sel     (clk_sel),
  .clk_trap    (clk_trap),
  .fell_back   (fell_back),
  .bor_sel     (bor_sel)
);

// File: tb/rst_clk_sequencer_bench.sv
module rst_clk_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int P_POR  = 8;
  localparam int P_PWRT = 24;
  localparam int P_OSC  = 16;
  localparam int WIN    = 110;
  localparam int NEVER  = 100000;
  localparam int TOL    = 2;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       por_req, bor_req, ext_req;
  logic [2:0] cfg_src;
  logic       cfg_fsafe_en, cfg_pwup_en;
  logic [1:0] cfg_bor_lvl;
  logic       osc_ready, pll_lock, trap_clr;
  logic       sys_rst, clk_gate_en;
  logic [2:0] clk_sel;
  logic       clk_trap, fell_back;
  logic [1:0] bor_sel;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  rst_clk_sequencer #(
    .POR_CYCLES (P_POR),
    .PWRT_CYCLES(P_PWRT),
    .OSC_CYCLES (P_OSC)
  ) u_rst_clk_sequencer (
    .clk_ref      (clk_ref),
    .rst_n        (rst_n),
    .por_req      (por_req),
    .bor_req      (bor_req),
    .ext_req      (ext_req),
    .cfg_src      (cfg_src),
    .cfg_fsafe_en (cfg_fsafe_en),
    .cfg_pwup_en  (cfg_pwup_en),
    .cfg_bor_lvl  (cfg_bor_lvl),
    .osc_ready    (osc_ready),
    .pll_lock     (pll_lock),
    .trap_clr     (trap_clr),
    .sys_rst      (sys_rst),
    .clk_gate_en  (clk_gate_en),
    .clk_sel      (clk_sel),
    .clk_trap     (clk_trap),
    .fell_back    (fell_back),
    .bor_sel      (bor_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit f_xtal(input logic [2:0] s);
    return (s == 3'd4) || (s == 3'd5) || (s == 3'd7);
  endfunction

  function automatic bit f_pll(input logic [2:0] s);
    return (s == 3'd5) || (s == 3'd6);
  endfunction

  // Edge (after the release edge) at which the delays end
  function automatic int f_tdec(input bit pw);
    return pw ? (P_POR + P_PWRT + 4) : (P_POR + 3);
  endfunction

  // Edge at which the clock becomes usable; 0 when usable at once
  function automatic int f_tok(input logic [2:0] s, input int dosc, input int dlock);
    int t = 0;
    if (f_xtal(s)) begin
      if (dosc < 0) return NEVER;
      t = ((dosc + 1 > 2) ? dosc + 1 : 2) + P_OSC + 1;
    end
    if (f_pll(s)) begin
      if (dlock < 0) return NEVER;
      if (dlock + 2 > t) t = dlock + 2;
    end
    return t;
  endfunction

  function automatic int f_abs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic assert_req(input int cycles);
    int kind = $urandom_range(0, 2);
    @(negedge clk_ref);
    por_req = (kind == 0);
    bor_req = (kind == 1);
    ext_req = (kind == 2);
    repeat (cycles) @(negedge clk_ref);
  endtask

  task automatic run_trial(input logic [2:0] s, input bit fs, input bit pw,
                           input logic [1:0] lvl, input int dosc, input int dlock);
    int  rel = -1;
    int  tdec, tok, exp_rel;
    bit  exp_trap;
    bit  gate_bad = 0;
    string tag;
    osc_ready = 1'b0;
    pll_lock  = 1'b0;
    cfg_src = s; cfg_fsafe_en = fs; cfg_pwup_en = pw; cfg_bor_lvl = lvl;
    assert_req(4 + $urandom_range(0, 4));
    por_req = 1'b0; bor_req = 1'b0; ext_req = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      if (k == dosc)  osc_ready = 1'b1;
      if (k == dlock) pll_lock  = 1'b1;
      @(negedge clk_ref);
      if (!sys_rst && rel < 0) rel = k;
      if (clk_gate_en !== !sys_rst) gate_bad = 1;
    end
    tdec = f_tdec(pw);
    tok  = f_tok(s, dosc, dlock);
    exp_trap = (tok > tdec) && fs;
    exp_rel  = (tok <= tdec || fs) ? tdec : tok;
    if (exp_trap) tag = "R5";
    else if (tok > tdec) tag = "R6";
    else if (pw) tag = "R2";
    else tag = "R3";
    if (exp_rel >= NEVER) begin
      chk("R6 never-ready stays in reset", rel, -1);
    end else begin
      chk({tag, " release edge within tolerance"},
          (rel >= 0 && f_abs(rel - exp_rel) <= TOL) ? exp_rel : rel, exp_rel);
    end
    chk("R11 gate tracks reset", gate_bad, 0);
    chk("R5 trap level", clk_trap, exp_trap);
    chk("R5 fallback status", fell_back, exp_trap);
    if (exp_rel < NEVER)
      chk("R4 clock select", clk_sel, exp_trap ? 0 : s);
    chk("R10 brown-out level", bor_sel, (lvl == 2'd3) ? 2 : lvl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_ref);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int tdec_pw;
    int rel2;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    por_req = 1'b1; bor_req = 1'b0; ext_req = 1'b0;
    cfg_src = 3'd0; cfg_fsafe_en = 1'b0; cfg_pwup_en = 1'b1; cfg_bor_lvl = 2'd0;
    osc_ready = 1'b0; pll_lock = 1'b0; trap_clr = 1'b0;
    repeat (3) @(negedge clk_ref);
    // R1: reset state
    chk("R1 sys_rst in reset", sys_rst, 1);
    chk("R1 gate in reset", clk_gate_en, 0);
    chk("R1 trap in reset", clk_trap, 0);
    chk("R1 fallback in reset", fell_back, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_ref);

    // Directed corner cases
    run_trial(3'd4, 1, 1, 2'd1, 0, -1);   // R2 crystal ready before power-up ends
    run_trial(3'd4, 1, 0, 2'd0, 0, -1);   // R5 crystal not ready, fail-safe
    // R7: trap cleared by trap_clr, status kept
    @(negedge clk_ref); trap_clr = 1'b1;
    @(negedge clk_ref); trap_clr = 1'b0;
    @(negedge clk_ref);
    chk("R7 trap cleared", clk_trap, 0);
    chk("R7 fallback kept", fell_back, 1);
    chk("R7 select kept on fast RC", clk_sel, 0);
    // R9: configuration changes after release ignored
    cfg_src = 3'd6; cfg_bor_lvl = 2'd2;
    repeat (6) @(negedge clk_ref);
    chk("R9 clk_sel unchanged", clk_sel, 0);
    chk("R9 bor_sel unchanged", bor_sel, 0);
    run_trial(3'd4, 0, 0, 2'd3, 0, -1);   // R6 wait for crystal count
    run_trial(3'd0, 0, 0, 2'd2, -1, -1);  // R3 fast RC, immediate
    run_trial(3'd5, 0, 1, 2'd0, 0, -1);   // R6 PLL never locks
    run_trial(3'd6, 1, 1, 2'd1, -1, 50);  // R5 PLL lock too late
    run_trial(3'd7, 0, 1, 2'd3, 0, 3);    // R4 high-speed crystal

    // R8: abort during the power-on/power-up delay, then restart
    cfg_src = 3'd1; cfg_fsafe_en = 1'b0; cfg_pwup_en = 1'b1; cfg_bor_lvl = 2'd0;
    assert_req(5);
    por_req = 1'b0; bor_req = 1'b0; ext_req = 1'b0;
    repeat (12) @(negedge clk_ref);
    chk("R8 still in reset mid-sequence", sys_rst, 1);
    assert_req(4);
    por_req = 1'b0; bor_req = 1'b0; ext_req = 1'b0;
    rel2 = -1;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk_ref);
      if (!sys_rst && rel2 < 0) rel2 = k;
    end
    tdec_pw = f_tdec(1);
    chk("R8 restarted release edge",
        (rel2 >= 0 && f_abs(rel2 - tdec_pw) <= TOL) ? tdec_pw : rel2, tdec_pw);
    chk("R7 fallback cleared by new reset", fell_back, 0);
    chk("R4 slow RC selected", clk_sel, 1);

    // Constrained random trials
    for (int i = 0; i < 30; i++) begin
      logic [2:0] s;
      bit fs, pw;
      int dosc, dlock, tk, td;
      logic [1:0] lvl;
      do begin
        s  = 3'($urandom_range(0, 7));
        fs = 1'($urandom_range(0, 1));
        pw = 1'($urandom_range(0, 1));
        lvl = 2'($urandom_range(0, 3));
        dosc  = ($urandom_range(0, 9) == 0) ? -1 : $urandom_range(0, 60);
        dlock = ($urandom_range(0, 9) == 0) ? -1 : $urandom_range(0, 60);
        tk = f_tok(s, dosc, dlock);
        td = f_tdec(pw);
      end while (tk != 0 && tk < NEVER && f_abs(tk - td) < 5);
      run_trial(s, fs, pw, lvl, dosc, dlock);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule